// File: doc/BRIEF.md
# Nonvolatile Memory Command Unit

This block is the register-level front end of a nonvolatile program-memory controller. Software reaches it through a simple 32-bit register bus. It holds a control/status word, a write-only key port, a target address, a word of program data and a row source address. The memory array is not part of the block. Accepted operations go to a back-end through a request/done handshake. The back-end reports completion with a one-cycle done pulse, together with an operation-error flag and a low-voltage-error flag.

Erase and program commands are guarded. Software first stores an operation code with the enable bit set. It then writes two fixed key words back to back into the key port. Only then does it raise the start bit, usually through the set alias of the control word. The start bit reads as one for as long as the operation runs and falls when the back-end reports done. The error flags are then valid in the same word. The target address is held as a physical address, and the back-end receives it aligned to the granule of the chosen operation.

Top module: `nvm_cmd_unit`

## Requirements
- R1: After synchronous reset, every register reads zero (bit 11 of the control word follows `lv_low`) and `be_req` is low.
- R2: The control word is at offset 0x00. Bits [3:0] hold the operation code, bit 15 start/busy, bit 14 enable, bit 13 operation error, bit 12 low-voltage error, and bit 11 is the read-only level of `lv_low`. All other bits read zero. A write to offset 0x00 replaces bits 14, 13, 12 and [3:0].
- R3: A write to offset 0x04 clears the one-bits of the written data in the control word, a write to 0x08 sets them, and a write to 0x0C inverts them.
- R4: The target address (offset 0x20) stores the written value with bits [31:29] forced to zero. The data word (0x30) and the source address (0x40) store all 32 bits.
- R5: A start (any control-word write that leaves bit 15 at one while idle) is accepted only if both of these hold. First, the enable bit was already one. Second, the two bus writes just before it were 0xAA996655 and then 0x556699AA to the key port at offset 0x10. The cycle after acceptance, bit 15 reads one and `be_req` is high.
- R6: A start is ignored, so bit 15 stays zero and `be_req` stays low, in each of these cases: a wrong key, keys in the wrong order, any bus write between the two keys or between the second key and the start, or the enable bit clear.
- R7: While busy, writes to the target address, data word, source address and operation-code field have no effect.
- R8: Accepting a start clears both error bits. On a `be_done` pulse while busy, bit 15 and `be_req` drop on the next cycle, bit 13 takes `be_err` and bit 12 takes `be_lverr`.
- R9: `be_addr` is the target address aligned down to 4 bytes for word program (op 0x1), to ROW_BYTES (512) for row program (0x3) and to PAGE_BYTES (4096) for page erase (0x4). For any other code it is passed through unchanged. With SMALL_PART set, the row and page sizes are 128 and 1024.
- R10: The key port reads as zero.
- R11: Software cannot clear bit 15 while an operation runs. Neither the clear alias nor a plain write ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_rdata | output | 32 | Registered read data |
| be_req | output | 1 | Operation in progress, request to back-end |
| be_op | output | 4 | Operation code of the request |
| be_addr | output | 32 | Aligned physical target address |
| be_data | output | 32 | Word to program |
| be_src | output | 32 | Row source address |
| be_done | input | 1 | One-cycle completion pulse |
| be_err | input | 1 | Operation error, valid with be_done |
| be_lverr | input | 1 | Low-voltage error, valid with be_done |
| lv_low | input | 1 | Low-voltage status level |

## Verification
Problems in the unlock tracker are visible at the ports immediately. A stale armed state lets `be_req` rise one cycle after a start that should have been refused. A lost armed state keeps `be_req` low after a correct sequence. A wrong busy flag shows on `be_req` one cycle after the start or done edge, and as frozen or unfrozen register readback on the next read. Alignment faults appear on `be_addr` combinationally, as soon as the operation code or address register changes. The sweeps over codes and addresses therefore catch a wrong mask on the very next sample.

// File: rtl/nvmc_pkg.sv
package nvmc_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CLR  = 8'h04;
    localparam logic [7:0] OFS_SET  = 8'h08;
    localparam logic [7:0] OFS_INV  = 8'h0C;
    localparam logic [7:0] OFS_KEY  = 8'h10;
    localparam logic [7:0] OFS_TGT  = 8'h20;
    localparam logic [7:0] OFS_DAT  = 8'h30;
    localparam logic [7:0] OFS_SRC  = 8'h40;

    localparam logic [31:0] KEY_FIRST  = 32'hAA99_6655;
    localparam logic [31:0] KEY_SECOND = 32'h5566_99AA;
    localparam logic [31:0] PHYS_MASK  = 32'h1FFF_FFFF;

    localparam int BIT_START = 15;
    localparam int BIT_WREN  = 14;
    localparam int BIT_ERR   = 13;
    localparam int BIT_LVERR = 12;
    localparam int BIT_LVST  = 11;

    localparam logic [3:0] OP_NOP  = 4'h0;
    localparam logic [3:0] OP_WORD = 4'h1;
    localparam logic [3:0] OP_ROW  = 4'h3;
    localparam logic [3:0] OP_PAGE = 4'h4;
    localparam logic [3:0] OP_ALL  = 4'h5;

    typedef enum logic [1:0] {
        UNL_IDLE  = 2'd0,
        UNL_HALF  = 2'd1,
        UNL_ARMED = 2'd2
    } unlock_e;

    typedef struct packed {
        logic       busy;
        logic       wren;
        logic       err;
        logic       lverr;
        logic [3:0] op;
    } ctrl_s;

    function automatic logic [31:0] align_target(
        input logic [3:0]  op,
        input logic [31:0] a,
        input logic [31:0] row_b,
        input logic [31:0] page_b
    );
        logic [31:0] r;
        case (op)
            OP_WORD: r = a & ~32'd3;
            OP_ROW:  r = a & ~(row_b - 32'd1);
            OP_PAGE: r = a & ~(page_b - 32'd1);
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nvm_unlock_tracker.sv
module nvm_unlock_tracker
    import nvmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        any_wr,
    input  logic        key_wr,
    input  logic [31:0] wdata,
    output logic        armed
);
    unlock_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (any_wr) begin
            if (key_wr && wdata == KEY_FIRST)
                state_d = UNL_HALF;
            else if (state_q == UNL_HALF && key_wr && wdata == KEY_SECOND)
                state_d = UNL_ARMED;
            else
                state_d = UNL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= UNL_IDLE;
        else     state_q <= state_d;
    end

    assign armed = (state_q == UNL_ARMED);

    assert_arm_by_key_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(key_wr && wdata == KEY_SECOND));

    assert_write_disarms_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && any_wr) |=> !armed);

endmodule

// File: rtl/nvm_ctrl_status.sv
module nvm_ctrl_status
    import nvmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_base,
    input  logic        wr_clr,
    input  logic        wr_set,
    input  logic        wr_inv,
    input  logic [15:0] wdata,
    input  logic        armed,
    input  logic        be_done,
    input  logic        be_err,
    input  logic        be_lverr,
    input  logic        lv_low,
    output ctrl_s       ctl,
    output logic [31:0] ctrl_word
);
    logic [15:0] cur, nxt;
    logic        ctrl_wr, accept;

    always_comb begin
        cur = {ctl.busy, ctl.wren, ctl.err, ctl.lverr, 8'h00, ctl.op};
        nxt = cur;
        if (wr_base)     nxt = wdata;
        else if (wr_clr) nxt = cur & ~wdata;
        else if (wr_set) nxt = cur | wdata;
        else if (wr_inv) nxt = cur ^ wdata;
        ctrl_wr = wr_base | wr_clr | wr_set | wr_inv;
        accept  = ctrl_wr && nxt[BIT_START] && !ctl.busy && ctl.wren && armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (ctrl_wr) begin
                ctl.wren  <= nxt[BIT_WREN];
                ctl.err   <= nxt[BIT_ERR];
                ctl.lverr <= nxt[BIT_LVERR];
                if (!ctl.busy) ctl.op <= nxt[3:0];
            end
            if (accept) begin
                ctl.busy  <= 1'b1;
                ctl.err   <= 1'b0;
                ctl.lverr <= 1'b0;
            end else if (ctl.busy && be_done) begin
                ctl.busy  <= 1'b0;
                ctl.err   <= be_err;
                ctl.lverr <= be_lverr;
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[BIT_START] = ctl.busy;
        ctrl_word[BIT_WREN]  = ctl.wren;
        ctrl_word[BIT_ERR]   = ctl.err;
        ctrl_word[BIT_LVERR] = ctl.lverr;
        ctrl_word[BIT_LVST]  = lv_low;
        ctrl_word[3:0]       = ctl.op;
    end

    assert_start_guarded_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.busy) |-> $past(armed && ctl.wren));

    assert_errs_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.busy) |-> (!ctl.err && !ctl.lverr));

    assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && be_done) |=> (!ctl.busy && ctl.err == $past(be_err)));

    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && !be_done) |=> ctl.busy);

    assert_op_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.busy |=> $stable(ctl.op));

endmodule

// File: rtl/nvm_target_regs.sv
module nvm_target_regs
    import nvmc_pkg::*;
#(
    parameter int unsigned ROW_B  = 512,
    parameter int unsigned PAGE_B = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  logic        wr_tgt,
    input  logic        wr_dat,
    input  logic        wr_src,
    input  logic [31:0] wdata,
    input  logic [3:0]  op,
    output logic [31:0] tgt_q,
    output logic [31:0] dat_q,
    output logic [31:0] src_q,
    output logic [31:0] tgt_aligned
);
    localparam logic [31:0] ROW_W  = 32'(ROW_B);
    localparam logic [31:0] PAGE_W = 32'(PAGE_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            dat_q <= '0;
            src_q <= '0;
        end else if (!busy) begin
            if (wr_tgt) tgt_q <= wdata & PHYS_MASK;
            if (wr_dat) dat_q <= wdata;
            if (wr_src) src_q <= wdata;
        end
    end

    assign tgt_aligned = align_target(op, tgt_q, ROW_W, PAGE_W);

    assert_tgt_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(tgt_q));
    assert_dat_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dat_q));
    assert_src_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(src_q));

endmodule

// File: rtl/nvm_cmd_unit.sv
module nvm_cmd_unit
    import nvmc_pkg::*;
#(
    parameter bit SMALL_PART = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        be_req,
    output logic [3:0]  be_op,
    output logic [31:0] be_addr,
    output logic [31:0] be_data,
    output logic [31:0] be_src,
    input  logic        be_done,
    input  logic        be_err,
    input  logic        be_lverr,
    input  logic        lv_low
);
    localparam int unsigned ROW_BYTES  = SMALL_PART ? 128  : 512;
    localparam int unsigned PAGE_BYTES = SMALL_PART ? 1024 : 4096;

    logic        wr_base, wr_clr, wr_set, wr_inv, wr_key, wr_tgt, wr_dat, wr_src;
    logic        armed;
    ctrl_s       ctl;
    logic [31:0] ctrl_word, tgt_q, dat_q, src_q, tgt_aligned;

    always_comb begin
        wr_base = bus_wr && bus_addr == OFS_CTRL;
        wr_clr  = bus_wr && bus_addr == OFS_CLR;
        wr_set  = bus_wr && bus_addr == OFS_SET;
        wr_inv  = bus_wr && bus_addr == OFS_INV;
        wr_key  = bus_wr && bus_addr == OFS_KEY;
        wr_tgt  = bus_wr && bus_addr == OFS_TGT;
        wr_dat  = bus_wr && bus_addr == OFS_DAT;
        wr_src  = bus_wr && bus_addr == OFS_SRC;
    end

    nvm_unlock_tracker i_unlock (
        .clk    (clk),
        .rst    (rst),
        .any_wr (bus_wr),
        .key_wr (wr_key),
        .wdata  (bus_wdata),
        .armed  (armed)
    );

    nvm_ctrl_status i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_base   (wr_base),
        .wr_clr    (wr_clr),
        .wr_set    (wr_set),
        .wr_inv    (wr_inv),
        .wdata     (bus_wdata[15:0]),
        .armed     (armed),
        .be_done   (be_done),
        .be_err    (be_err),
        .be_lverr  (be_lverr),
        .lv_low    (lv_low),
        .ctl       (ctl),
        .ctrl_word (ctrl_word)
    );

    nvm_target_regs #(
        .ROW_B  (ROW_BYTES),
        .PAGE_B (PAGE_BYTES)
    ) i_tregs (
        .clk         (clk),
        .rst         (rst),
        .busy        (ctl.busy),
        .wr_tgt      (wr_tgt),
        .wr_dat      (wr_dat),
        .wr_src      (wr_src),
        .wdata       (bus_wdata),
        .op          (ctl.op),
        .tgt_q       (tgt_q),
        .dat_q       (dat_q),
        .src_q       (src_q),
        .tgt_aligned (tgt_aligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL, OFS_CLR, OFS_SET, OFS_INV: bus_rdata <= ctrl_word;
                OFS_TGT: bus_rdata <= tgt_q;
                OFS_DAT: bus_rdata <= dat_q;
                OFS_SRC: bus_rdata <= src_q;
                default: bus_rdata <= '0;
            endcase
        end
    end

    assign be_req  = ctl.busy;
    assign be_op   = ctl.op;
    assign be_addr = tgt_aligned;
    assign be_data = dat_q;
    assign be_src  = src_q;

endmodule

// File: tb/test_nvm_cmd_unit.sv
`timescale 1ns/1ps
module test_nvm_cmd_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        be_req;
    logic [3:0]  be_op;
    logic [31:0] be_addr, be_data, be_src;
    logic        be_done = 1'b0, be_err = 1'b0, be_lverr = 1'b0, lv_low = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nvm_cmd_unit i_nvm_cmd_unit (
        .clk, .rst, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
        .be_req, .be_op, .be_addr, .be_data, .be_src,
        .be_done, .be_err, .be_lverr, .lv_low
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_op(input logic e, input logic lv);
        @(negedge clk);
        be_done = 1'b1; be_err = e; be_lverr = lv;
        @(negedge clk);
        be_done = 1'b0; be_err = 1'b0; be_lverr = 1'b0;
    endtask

    // refused start: check nothing began
    task automatic expect_refused(input string req);
        logic [31:0] v;
        chk(req, {31'b0, be_req}, 32'h0);
        rd(8'h00, v);
        chk(req, {31'b0, v[15]}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 be_req", {31'b0, be_req}, 32'h0);
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h20, v); chk("R1 tgt", v, 32'h0);
        rd(8'h30, v); chk("R1 dat", v, 32'h0);
        rd(8'h40, v); chk("R1 src", v, 32'h0);

        // R2 plain write, lv status follows pin; start bit without unlock refused (R6)
        lv_low = 1'b1;
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 plain write", v, 32'h0000_780F);
        chk("R6 start without keys", {31'b0, be_req}, 32'h0);
        lv_low = 1'b0;

        // R3 aliases
        wr(8'h04, 32'h0000_2000); rd(8'h00, v); chk("R3 clr", v, 32'h0000_500F);
        wr(8'h04, 32'h0000_000F); rd(8'h00, v); chk("R3 clr op", v, 32'h0000_5000);
        wr(8'h08, 32'h0000_0003); rd(8'h00, v); chk("R3 set", v, 32'h0000_5003);
        wr(8'h0C, 32'h0000_1006); rd(8'h00, v); chk("R3 inv", v, 32'h0000_4005);
        rd(8'h08, v); chk("R3 alias readback", v, 32'h0000_4005);
        wr(8'h00, 32'h0);

        // R4 address masking sweep, data and source full width
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            a = 32'h2468_ACE1 * (k + 3) + {k[2:0], 29'h0};
            wr(8'h20, a); rd(8'h20, v);
            chk("R4 tgt mask", v, a % 32'h2000_0000);
        end
        wr(8'h30, 32'hDEAD_BEEF); rd(8'h30, v); chk("R4 dat", v, 32'hDEAD_BEEF);
        wr(8'h40, 32'hF00D_CAFE); rd(8'h40, v); chk("R4 src", v, 32'hF00D_CAFE);

        // R10 key port reads zero
        wr(8'h10, 32'h1234_5678); rd(8'h10, v); chk("R10 key read", v, 32'h0);

        // R9 alignment sweep over codes and addresses
        for (int oi = 0; oi < 6; oi++) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] a, m, e;
                a = 32'hE135_79BD + 32'h0001_0F37 * k;
                wr(8'h00, 32'(oi));
                wr(8'h20, a);
                m = a % 32'h2000_0000;
                case (oi)
                    1: e = m - (m % 4);
                    3: e = m - (m % 512);
                    4: e = m - (m % 4096);
                    default: e = m;
                endcase
                @(negedge clk);
                chk($sformatf("R9 align op%0d", oi), be_addr, e);
            end
        end

        // R5 correct sequence starts a page erase
        wr(8'h20, 32'h1D00_3000);
        wr(8'h30, 32'h1111_2222);
        wr(8'h00, 32'h0000_4004);
        wr(8'h10, 32'hAA99_6655);
        wr(8'h10, 32'h5566_99AA);
        wr(8'h08, 32'h0000_8000);
        chk("R5 be_req", {31'b0, be_req}, 32'h1);
        chk("R5 be_op", {28'b0, be_op}, 32'h4);
        chk("R5 be_addr", be_addr, 32'h1D00_3000);
        rd(8'h00, v); chk("R5 ctrl busy", v, 32'h0000_C004);

        // R7 writes blocked while busy
        wr(8'h20, 32'h0000_0040);
        wr(8'h30, 32'h5555_5555);
        wr(8'h40, 32'h7777_7777);
        wr(8'h00, 32'h0000_C001);
        rd(8'h20, v); chk("R7 tgt blocked", v, 32'h1D00_3000);
        rd(8'h30, v); chk("R7 dat blocked", v, 32'h1111_2222);
        rd(8'h40, v); chk("R7 src blocked", v, 32'hF00D_CAFE);
        chk("R7 op blocked", {28'b0, be_op}, 32'h4);

        // R11 software cannot end the operation
        wr(8'h04, 32'h0000_8000);
        chk("R11 clr alias", {31'b0, be_req}, 32'h1);
        wr(8'h00, 32'h0000_4004);
        rd(8'h00, v); chk("R11 plain write", v, 32'h0000_C004);

        // R8 done with operation error
        finish_op(1'b1, 1'b0);
        chk("R8 req drops", {31'b0, be_req}, 32'h0);
        rd(8'h00, v); chk("R8 err latched", v, 32'h0000_6004);

        // R8 new accept clears errors; then low-voltage error
        wr(8'h10, 32'hAA99_6655);
        wr(8'h10, 32'h5566_99AA);
        wr(8'h08, 32'h0000_8000);
        rd(8'h00, v); chk("R8 errs cleared", v, 32'h0000_C004);
        finish_op(1'b0, 1'b1);
        rd(8'h00, v); chk("R8 lverr latched", v, 32'h0000_5004);
        wr(8'h04, 32'h0000_3000);

        // R6 refusal cases
        wr(8'h10, 32'hAA99_6656);
        wr(8'h10, 32'h5566_99AA);
        wr(8'h08, 32'h0000_8000);
        expect_refused("R6 wrong first key");

        wr(8'h10, 32'hAA99_6655);
        wr(8'h10, 32'h5566_99AB);
        wr(8'h08, 32'h0000_8000);
        expect_refused("R6 wrong second key");

        wr(8'h10, 32'h5566_99AA);
        wr(8'h10, 32'hAA99_6655);
        wr(8'h08, 32'h0000_8000);
        expect_refused("R6 reversed keys");

        wr(8'h10, 32'hAA99_6655);
        wr(8'h30, 32'h0);
        wr(8'h10, 32'h5566_99AA);
        wr(8'h08, 32'h0000_8000);
        expect_refused("R6 write between keys");

        wr(8'h10, 32'hAA99_6655);
        wr(8'h10, 32'h5566_99AA);
        wr(8'h30, 32'h0);
        wr(8'h08, 32'h0000_8000);
        expect_refused("R6 write before start");

        wr(8'h00, 32'h0000_0004);
        wr(8'h10, 32'hAA99_6655);
        wr(8'h10, 32'h5566_99AA);
        wr(8'h08, 32'h0000_C000);
        expect_refused("R6 enable clear");

        // R5 start through invert alias after proper sequence
        wr(8'h00, 32'h0000_4003);
        wr(8'h10, 32'hAA99_6655);
        wr(8'h10, 32'h5566_99AA);
        wr(8'h0C, 32'h0000_8000);
        chk("R5 inv start", {31'b0, be_req}, 32'h1);
        chk("R5 row op", {28'b0, be_op}, 32'h3);
        finish_op(1'b0, 1'b0);
        rd(8'h00, v); chk("R8 clean done", v, 32'h0000_4003);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule